// File: doc/BRIEF.md
# UART Receive FIFO with DMA Request

This block is the receive half of a serial port. It recovers 8N1 characters from an asynchronous serial input by oversampling, stores them in a small FIFO, and signals a DMA controller when there is data to collect. It raises a request in two cases. The first is when the fill level reaches a programmable trigger level. The second is when data sits below that level and the line has been quiet for four character times. Neither the DMA event nor the interrupt says which of the two cases caused it. In the timeout case the DMA is expected to take one byte per event. The timeout then restarts after each read, so every remaining byte costs another four character times. Choosing a trigger level that suits the transfer size is therefore the system's main tuning knob.

Software reaches the block through a small byte-wide register port. The control register is write-only. It shares its offset with a read-only identification register, so a read at that offset never returns the control value. Any read-modify-write of the control settings must therefore come from a software copy of those settings. A line-status register reports data-ready and the two error flags.

Top module: `uart_rx_dma`

## Requirements
- R1: A character is a low start bit, 8 data bits sent LSB first, and a stop bit. The line is sampled 16 times per bit. A start is accepted only if the line is still low at the start bit's midpoint; a shorter low pulse is discarded. A read at offset 0 pops the oldest byte.
- R2: The line-status register at offset 2 reads bit0 = FIFO not empty, bit1 = overrun, bit2 = framing error (the stop bit was sampled low). Bits 2:1 are sticky and are cleared by a read of offset 2.
- R3: With the FIFO enabled it holds 16 bytes and returns them in arrival order. A character that arrives while it is full is dropped and sets the overrun flag.
- R4: A read at offset 0 from an empty FIFO returns 0x00 and leaves the fill level unchanged.
- R5: A write at offset 1 loads the control register. A read at offset 1 returns the identification value: bit0 = 1 when no request is pending, bits 3:1 = 3'b010 for trigger level reached or 3'b110 for character timeout, bits 7:6 = 2'b11 while the FIFO is enabled.
- R6: Control bit0 enables the FIFO. Bit1 clears the receive FIFO. Bit2 is the transmit clear and has no effect on the receive side. Bit3 enables DMA events. Bits 7:6 select the trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes.
- R7: The DMA event output is a single-cycle pulse. One pulse is issued when the fill level rises to the trigger level.
- R8: With the FIFO enabled and 0 < level < trigger, if no character arrives and no byte is read for 4 character times (640 oversample ticks), a DMA pulse is issued and the identification value reports a timeout. The timer restarts after every read and after every expiry.
- R9: With the FIFO disabled the receive store holds one byte. Each completed character produces one event. A second character that arrives before the first is read is dropped and sets the overrun flag.
- R10: Writing control bit1 = 1 empties the FIFO and resets the timeout timer within the same cycle. No pending request remains afterwards.
- R11: With bit3 = 0 no DMA pulse is issued. The interrupt output still follows the pending trigger or timeout condition.
- R12: After reset the FIFO is disabled, DMA is off, the trigger level is 1, the FIFO is empty, and both the DMA and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| dma_evt_o | output | 1 | One-cycle DMA request pulse |
| irq_o | output | 1 | Level interrupt: trigger reached or timeout pending |

## Verification
A stimulus table sends byte patterns with all zeros, all ones, alternating bits and a low stop bit, one character at a time in single-byte mode. This separates bit-order and framing errors from FIFO effects. Back-to-back bursts at trigger levels 4 and 8 show that the request fires exactly at the threshold and not one byte early. A short burst below level 14 with no reads measures the first timeout delay, and then the re-arm delay after a single read. That interval is what separates a timer restarted by reads from a free-running one. A 17-byte burst with DMA off, a clear issued while data is pending, and a transmit-clear write show overflow handling, the clear's reset of the timer, and the bit that must be ignored.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_LINE = 2'd2;

  localparam logic [2:0] ID_NONE = 3'b000;
  localparam logic [2:0] ID_TRIG = 3'b010;
  localparam logic [2:0] ID_TMO  = 3'b110;

  typedef struct packed {
    logic [1:0] trig_sel;
    logic       dma_mode;
    logic       fifo_en;
  } rx_ctrl_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    unique case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVS           = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              tick_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o
);

  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int DIV_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [OVS_W-1:0] MID      = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] LAST     = OVS_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         state_q;
  logic [OVS_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              armed_q;
  logic              valid_q;
  logic              fe_q;

  generate
    if (CLKS_PER_TICK == 1) begin : g_tick_every
      assign tick_o = 1'b1;
    end else begin : g_tick_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else if (div_q == DIV_W'(CLKS_PER_TICK - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DIV_W'(CLKS_PER_TICK - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_o) begin
        unique case (state_q)
          RX_IDLE: begin
            // a start needs a high level seen first, so a low stop bit cannot retrigger
            if (rx_s) armed_q <= 1'b1;
            else if (armed_q) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
              if (bit_q == LAST_BIT) state_q <= RX_STOP;
              else bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              valid_q <= 1'b1;
              fe_q    <= !rx_s;
              armed_q <= 1'b0;
              state_q <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign valid_o     = valid_q;
  assign data_o      = sh_q;
  assign frame_err_o = fe_q;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              single_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign full_o  = single_i ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/uart_rx_evt.sv
module uart_rx_evt
  import uart_rx_pkg::*;
#(
  parameter int TMO_TICKS = 640,
  parameter int CW        = 5,
  localparam int TW       = $clog2(TMO_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          arrive_i,
  input  logic          pop_i,
  input  logic          clr_i,
  input  logic          fifo_en_i,
  input  logic          dma_mode_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] count_i,
  output logic          evt_o,
  output logic          trig_hit_o,
  output logic          tmo_flag_o,
  output logic [TW-1:0] tmo_cnt_o
);

  int unsigned   trig_eff;
  logic          trig_hit, tmo_run, expire;
  logic          hit_q, evt_q, flag_q;
  logic [TW-1:0] tmo_q;

  assign trig_eff = fifo_en_i ? trig_level(trig_sel_i) : 1;
  assign trig_hit = 32'(count_i) >= trig_eff;
  assign tmo_run  = fifo_en_i && (count_i != '0) && !trig_hit;
  assign expire   = tmo_run && tick_i && (tmo_q == TW'(TMO_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= '0;
      flag_q <= 1'b0;
      hit_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      // any arrival, read, clear or expiry restarts the quiet-line window
      if (clr_i || arrive_i || pop_i || !tmo_run || expire) tmo_q <= '0;
      else if (tick_i) tmo_q <= tmo_q + 1'b1;

      if (clr_i || arrive_i || pop_i || count_i == '0) flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;

      hit_q <= trig_hit;
      evt_q <= dma_mode_i && ((trig_hit && !hit_q) || expire);
    end
  end

  assign evt_o      = evt_q;
  assign trig_hit_o = trig_hit;
  assign tmo_flag_o = flag_q;
  assign tmo_cnt_o  = tmo_q;

endmodule

// File: rtl/uart_rx_dma.sv
module uart_rx_dma
  import uart_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVS           = 16,
  parameter int DEPTH         = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       dma_evt_o,
  output logic       irq_o
);

  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int TMO_TICKS  = TMO_CHARS * FRAME_BITS * OVS;
  localparam int CW         = $clog2(DEPTH) + 1;
  localparam int TW         = $clog2(TMO_TICKS + 1);

  rx_ctrl_t          ctrl_q;
  logic              tick, rx_valid, rx_fe;
  logic [DATA_W-1:0] rx_data, head;
  logic [CW-1:0]     fifo_cnt;
  logic              fifo_full, fifo_clr, pop;
  logic              trig_hit, tmo_flag, pending;
  logic [TW-1:0]     tmo_cnt;
  logic              oe_q, fe_q;
  logic [2:0]        id;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[5:4];

  uart_rx_deser #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .OVS          (OVS),
    .DATA_W       (DATA_W)
  ) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .tick_o     (tick),
    .valid_o    (rx_valid),
    .data_o     (rx_data),
    .frame_err_o(rx_fe)
  );

  assign fifo_clr = wr_i && (addr_i == OFS_CTRL) && wdata_i[1];
  assign pop      = rd_i && (addr_i == OFS_DATA) && (fifo_cnt != '0);

  uart_rx_fifo #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr),
    .single_i(!ctrl_q.fifo_en),
    .push_i  (rx_valid),
    .data_i  (rx_data),
    .pop_i   (pop),
    .data_o  (head),
    .count_o (fifo_cnt),
    .full_o  (fifo_full)
  );

  uart_rx_evt #(
    .TMO_TICKS(TMO_TICKS),
    .CW       (CW)
  ) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .arrive_i  (rx_valid),
    .pop_i     (pop),
    .clr_i     (fifo_clr),
    .fifo_en_i (ctrl_q.fifo_en),
    .dma_mode_i(ctrl_q.dma_mode),
    .trig_sel_i(ctrl_q.trig_sel),
    .count_i   (fifo_cnt),
    .evt_o     (dma_evt_o),
    .trig_hit_o(trig_hit),
    .tmo_flag_o(tmo_flag),
    .tmo_cnt_o (tmo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '{trig_sel: 2'b00, dma_mode: 1'b0, fifo_en: 1'b0};
    else if (wr_i && addr_i == OFS_CTRL)
      ctrl_q <= '{trig_sel: wdata_i[7:6], dma_mode: wdata_i[3], fifo_en: wdata_i[0]};
  end

  // sticky line errors: a new error in the read cycle wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      if (rx_valid && fifo_full) oe_q <= 1'b1;
      else if (rd_i && addr_i == OFS_LINE) oe_q <= 1'b0;
      if (rx_valid && rx_fe) fe_q <= 1'b1;
      else if (rd_i && addr_i == OFS_LINE) fe_q <= 1'b0;
    end
  end

  assign pending = trig_hit || tmo_flag;
  assign irq_o   = pending;
  assign id      = tmo_flag ? ID_TMO : (trig_hit ? ID_TRIG : ID_NONE);

  always_comb begin
    unique case (addr_i)
      OFS_DATA: rdata_o = (fifo_cnt != '0) ? head : '0;
      OFS_CTRL: rdata_o = {{2{ctrl_q.fifo_en}}, 2'b00, id, !pending};
      OFS_LINE: rdata_o = {5'b0, fe_q, oe_q, fifo_cnt != '0};
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/uart_rx_dma_chk.sv
module uart_rx_dma_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int TW    = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          wr_i,
  input logic [1:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          dma_evt_o,
  input logic          irq_o,
  input logic          fifo_en,
  input logic          dma_mode,
  input logic          push,
  input logic [CW-1:0] count,
  input logic [TW-1:0] tmo_cnt
);

  assert_evt_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_evt_o |=> !dma_evt_o);

  assert_no_evt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_mode && $past(!dma_mode)) |-> !dma_evt_o);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count) <= DEPTH);

  assert_empty_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd0 && count == '0) |-> rdata_o == 8'h00);

  assert_empty_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd0 && count == '0 && !push) |=> count == '0);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1 && wdata_i[1]) |=> (count == '0 && tmo_cnt == '0));

  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en && 32'(count) <= 1 && !(wr_i && addr_i == 2'd1 && wdata_i[0]))
      |=> 32'(count) <= 1);

  assert_ident_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd1) |-> (rdata_o[0] == !irq_o));

endmodule

bind uart_rx_dma uart_rx_dma_chk #(
  .DEPTH(DEPTH),
  .CW   (CW),
  .TW   (TW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .dma_evt_o(dma_evt_o),
  .irq_o    (irq_o),
  .fifo_en  (ctrl_q.fifo_en),
  .dma_mode (ctrl_q.dma_mode),
  .push     (rx_valid),
  .count    (fifo_cnt),
  .tmo_cnt  (tmo_cnt)
);

// File: tb/uart_rx_dma_tb.sv
module uart_rx_dma_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 16;
  localparam int NVEC       = 6;
  // {expected framing error, stop bit level, data}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'hFF},
    {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'h81}, {1'b0, 1'b1, 8'h5A}
  };

  logic       clk, rst_n, rx, rd, wr, dma_evt, irq;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;

  int checks = 0, errors = 0, cyc = 0, evt_cnt = 0, evt_cyc = 0;

  uart_rx_dma #(.CLKS_PER_TICK(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dma_evt_o(dma_evt), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (dma_evt) begin evt_cnt++; evt_cyc = cyc; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop);
    @(negedge clk);
    rx = 1'b0; idle(BIT_CYC);
    for (int b = 0; b < 8; b++) begin rx = d[b]; idle(BIT_CYC); end
    rx = stop; idle(BIT_CYC);
    rx = 1'b1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_evt(input int maxc, output bit got);
    int start;
    start = evt_cnt;
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (evt_cnt != start) begin got = 1'b1; return; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [9:0] e;
    int n0, t0, d;
    bit got;
    rx = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
    idle(5); rst_n = 1'b1; idle(5);

    // R12 reset state
    chk(dma_evt == 1'b0, "R12 dma idle", dma_evt, 0);
    chk(irq == 1'b0, "R12 irq idle", irq, 0);
    reg_rd(2'd1, v); chk(v == 8'h01, "R5 R12 ident after reset", v, 8'h01);
    reg_rd(2'd2, v); chk(v == 8'h00, "R2 R12 line after reset", v, 0);

    // R1 short glitch rejected
    rx = 1'b0; idle(4); rx = 1'b1; idle(40);
    reg_rd(2'd2, v); chk(v[0] == 1'b0, "R1 glitch ignored", v, 0);

    // R4 empty read
    reg_rd(2'd0, v); chk(v == 8'h00, "R4 empty read zero", v, 0);
    reg_rd(2'd2, v); chk(v[0] == 1'b0, "R4 level unchanged", v, 0);

    // table: single-byte mode with DMA on
    reg_wr(2'd1, 8'h08);
    for (int i = 0; i < NVEC; i++) begin
      e = VEC[i];
      n0 = evt_cnt;
      send(e[7:0], e[8]);
      idle(10);
      chk(evt_cnt == n0 + 1, "R9 one event per char", evt_cnt - n0, 1);
      reg_rd(2'd2, v);
      chk(v[0] == 1'b1, "R2 data ready", v[0], 1);
      chk(v[2] == e[9], "R2 framing flag", v[2], e[9]);
      reg_rd(2'd0, v);
      chk(v == e[7:0], "R1 data byte", v, e[7:0]);
    end

    // R9 overrun in single-byte mode
    send(8'hA1, 1'b1); send(8'hB2, 1'b1); idle(10);
    reg_rd(2'd2, v); chk(v[1] == 1'b1, "R9 overrun flag", v, 3);
    reg_rd(2'd0, v); chk(v == 8'hA1, "R9 first byte kept", v, 8'hA1);
    reg_rd(2'd2, v); chk(v == 8'h00, "R2 flags cleared by read", v, 0);

    // R6 R7 trigger level 4
    reg_wr(2'd1, 8'h4B);
    n0 = evt_cnt;
    for (int i = 0; i < 3; i++) send(8'h10 + 8'(i), 1'b1);
    idle(10);
    chk(evt_cnt == n0, "R7 below level 4", evt_cnt - n0, 0);
    send(8'h13, 1'b1); idle(10);
    chk(evt_cnt == n0 + 1, "R6 R7 event at level 4", evt_cnt - n0, 1);
    reg_rd(2'd1, v); chk(v == 8'hC4, "R5 ident trigger", v, 8'hC4);
    for (int i = 0; i < 4; i++) begin
      reg_rd(2'd0, v); chk(v == 8'h10 + 8'(i), "R3 order level 4", v, 8'h10 + i);
    end

    // R7 trigger level 8
    reg_wr(2'd1, 8'h8B);
    n0 = evt_cnt;
    for (int i = 0; i < 7; i++) send(8'h20 + 8'(i), 1'b1);
    idle(10);
    chk(evt_cnt == n0, "R7 below level 8", evt_cnt - n0, 0);
    reg_rd(2'd1, v); chk(v == 8'hC1, "R5 ident none", v, 8'hC1);
    send(8'h27, 1'b1); idle(10);
    chk(evt_cnt == n0 + 1, "R7 event at level 8", evt_cnt - n0, 1);
    for (int i = 0; i < 8; i++) begin
      reg_rd(2'd0, v); chk(v == 8'h20 + 8'(i), "R3 order level 8", v, 8'h20 + i);
    end

    // R8 character timeout and re-arm
    reg_wr(2'd1, 8'hCB);
    for (int i = 0; i < 3; i++) send(8'h30 + 8'(i), 1'b1);
    t0 = cyc;
    wait_evt(800, got);
    d = evt_cyc - t0;
    chk(got && d >= 600 && d <= 660, "R8 first timeout", d, 637);
    reg_rd(2'd1, v); chk(v == 8'hCC, "R5 ident timeout", v, 8'hCC);
    reg_rd(2'd0, v); chk(v == 8'h30, "R8 timeout byte", v, 8'h30);
    t0 = cyc;
    wait_evt(800, got);
    d = evt_cyc - t0;
    chk(got && d >= 630 && d <= 650, "R8 re-arm after read", d, 640);
    reg_rd(2'd0, v); chk(v == 8'h31, "R8 second byte", v, 8'h31);
    reg_rd(2'd0, v); chk(v == 8'h32, "R8 third byte", v, 8'h32);
    n0 = evt_cnt; idle(800);
    chk(evt_cnt == n0, "R8 silent when empty", evt_cnt - n0, 0);

    // R3 R11 overflow with DMA off
    reg_wr(2'd1, 8'hC3);
    n0 = evt_cnt;
    for (int i = 0; i < 17; i++) send(8'h40 + 8'(i), 1'b1);
    idle(10);
    chk(evt_cnt == n0, "R11 no DMA event", evt_cnt - n0, 0);
    chk(irq == 1'b1, "R11 irq still raised", irq, 1);
    reg_rd(2'd2, v); chk(v[1:0] == 2'b11, "R3 overrun when full", v, 3);
    for (int i = 0; i < 16; i++) begin
      reg_rd(2'd0, v); chk(v == 8'h40 + 8'(i), "R3 sixteen kept", v, 8'h40 + i);
    end
    reg_rd(2'd2, v); chk(v[0] == 1'b0, "R3 drained", v, 0);

    // R10 receive clear
    reg_wr(2'd1, 8'hC9);
    for (int i = 0; i < 3; i++) send(8'h60 + 8'(i), 1'b1);
    reg_wr(2'd1, 8'hCB);
    reg_rd(2'd2, v); chk(v[0] == 1'b0, "R10 FIFO emptied", v, 0);
    n0 = evt_cnt; idle(800);
    chk(evt_cnt == n0, "R10 no timeout after clear", evt_cnt - n0, 0);
    chk(irq == 1'b0, "R10 nothing pending", irq, 0);

    // R6 transmit clear leaves receive data alone
    send(8'h77, 1'b1); send(8'h88, 1'b1);
    reg_wr(2'd1, 8'hCD);
    reg_rd(2'd2, v); chk(v[0] == 1'b1, "R6 tx clear keeps data", v, 1);
    reg_rd(2'd0, v); chk(v == 8'h77, "R6 first byte intact", v, 8'h77);
    reg_rd(2'd0, v); chk(v == 8'h88, "R6 second byte intact", v, 8'h88);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule